// File: doc/BRIEF.md
# Gamepad Serial Link Responder

This block is the pad end of a synchronous, full-duplex, byte-serial gamepad link. A host drives a link clock that idles high, an active-low select that frames each poll, and a command line. In every bit slot the block takes one command bit and returns one response bit. Both sides change their line after a falling clock edge and sample on the rising edge. Every byte travels least-significant bit first. All three link inputs pass through two-flop synchronizers into the system clock domain, and edges are found there. The system clock must run at least eight times faster than the link clock.

A poll opens with command bytes 0x01 and 0x42, followed by 0x00 filler. The block answers with 0xFF, then an identity byte, then 0x5A, then two active-low button bytes, then an optional set of extension bytes. The identity byte's upper nibble gives the mode (0x4 digital, 0x7 extended). Its lower nibble gives the count of 16-bit payload words. The buttons and extension bytes are latched when select falls. If the command prefix is wrong, the block returns all ones for the rest of the window. If a poll is malformed or cut short, it raises an error level at deselect.

Top module: `pad_link_responder`

## Requirements
- R1: After reset and whenever select is high, `lnk_rsp` is 1. `poll_err` is 0 after reset.
- R2: `lnk_rsp` changes only after a falling link-clock edge. It holds steady through the high phase, where the host samples it. Each response byte is sent bit 0 first.
- R3: Response byte 0 is 0xFF and byte 2 is 0x5A. Byte 1 is 0x41 when ANA_WORDS is 0. Otherwise byte 1 is {4'h7, ANA_WORDS+1}, which is 0x72 for ANA_WORDS=1.
- R4: Byte 3 is `btn_n[7:0]` and byte 4 is `btn_n[15:8]`. Both are active low, so an idle pad returns 0xFF.
- R5: Bytes 5 to 4+2*ANA_WORDS carry `ana_in`, low byte first. A poll has 5+2*ANA_WORDS bytes in total.
- R6: Every byte clocked after the total is 0xFF. Such bytes do not by themselves set `poll_err`.
- R7: If command byte 0 is not 0x01, response bytes from byte 1 onward are 0xFF, and `poll_err` is 1 after deselect.
- R8: If command byte 1 is not 0x42, response bytes from byte 2 onward are 0xFF, and `poll_err` is 1 after deselect.
- R9: Button and extension inputs are sampled only at the falling edge of select. Changes during a poll do not affect that poll's reply.
- R10: A poll that ends with fewer complete bytes than the total sets `poll_err` at deselect. `poll_err` is cleared when the next poll's select falls, and each poll restarts at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_clk | input | 1 | Link clock from the host, idles high |
| lnk_sel_n | input | 1 | Active-low poll select |
| lnk_cmd | input | 1 | Command data from the host |
| lnk_rsp | output | 1 | Response data to the host |
| btn_n | input | 16 | Button states, active low |
| ana_in | input | 16*max(ANA_WORDS,1) | Extension payload bytes |
| poll_err | output | 1 | Last poll was malformed or aborted |

## Verification
The bench builds two copies side by side on the same link. One uses ANA_WORDS=1, a 7-byte reply with identity 0x72. The other uses ANA_WORDS=0, a 5-byte digital reply with identity 0x41. Because the two totals differ, a single 5-byte or 7-byte poll is exact length for one copy and short or over-long for the other. This exercises the error boundary and the trailing all-ones bytes in both directions. A walking-zero sweep over all sixteen button bits is run, together with full and empty patterns, so every payload bit position is tested in both responses.

// File: rtl/pad_link_responder.sv
module pad_link_responder #(
  parameter int ANA_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lnk_clk,
  input  logic lnk_sel_n,
  input  logic lnk_cmd,
  output logic lnk_rsp,
  input  logic [15:0] btn_n,
  input  logic [16*(ANA_WORDS > 0 ? ANA_WORDS : 1)-1:0] ana_in,
  output logic poll_err
);
  localparam int TOTAL = 5 + 2*ANA_WORDS;
  localparam int BW = $clog2(TOTAL + 1);
  localparam int AW = 16*(ANA_WORDS > 0 ? ANA_WORDS : 1);
  localparam logic [7:0] PAD_ID = (ANA_WORDS == 0) ? 8'h41 : {4'h7, 4'(ANA_WORDS + 1)};

  logic [2:0] ck_s, sel_s;
  logic [1:0] cmd_s;
  logic ck_rise, ck_fall, sel_rise, sel_fall, sel_q;
  logic [2:0] bit_cnt;
  logic [BW-1:0] byte_cnt;
  logic [7:0] rx_sh, rx_byte, tx_byte;
  logic cmd_bad;
  logic [15:0] btn_q;
  logic [AW-1:0] ana_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '1;
      sel_s <= '1;
      cmd_s <= '1;
    end else begin
      ck_s <= {ck_s[1:0], lnk_clk};
      sel_s <= {sel_s[1:0], lnk_sel_n};
      cmd_s <= {cmd_s[0], lnk_cmd};
    end

  assign sel_q = sel_s[1];
  assign ck_rise = ck_s[1] & ~ck_s[2];
  assign ck_fall = ~ck_s[1] & ck_s[2];
  assign sel_rise = sel_s[1] & ~sel_s[2];
  assign sel_fall = ~sel_s[1] & sel_s[2];
  assign rx_byte = {cmd_s[1], rx_sh[7:1]};

  always_comb begin
    tx_byte = 8'hFF;
    if (!cmd_bad && byte_cnt < BW'(TOTAL))
      case (int'(byte_cnt))
        0: tx_byte = 8'hFF;
        1: tx_byte = PAD_ID;
        2: tx_byte = 8'h5A;
        3: tx_byte = btn_q[7:0];
        4: tx_byte = btn_q[15:8];
        default: tx_byte = ana_q[8*(int'(byte_cnt) - 5) +: 8];
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      byte_cnt <= '0;
      rx_sh <= '0;
      cmd_bad <= 1'b0;
      lnk_rsp <= 1'b1;
      poll_err <= 1'b0;
      btn_q <= '1;
      ana_q <= '1;
    end else if (sel_q) begin
      bit_cnt <= '0;
      byte_cnt <= '0;
      rx_sh <= '0;
      cmd_bad <= 1'b0;
      lnk_rsp <= 1'b1;
      if (sel_rise) poll_err <= cmd_bad | (byte_cnt < BW'(TOTAL));
    end else begin
      if (sel_fall) begin
        btn_q <= btn_n;
        ana_q <= ana_in;
        poll_err <= 1'b0;
      end
      if (ck_fall) lnk_rsp <= tx_byte[bit_cnt];
      if (ck_rise) begin
        rx_sh <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt == BW'(0) && rx_byte != 8'h01) cmd_bad <= 1'b1;
          if (byte_cnt == BW'(1) && rx_byte != 8'h42) cmd_bad <= 1'b1;
          if (byte_cnt < BW'(TOTAL)) byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
endmodule

// File: rtl/pad_link_responder_chk.sv
module pad_link_responder_chk #(
  parameter int TOTAL = 9,
  parameter int BW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sel_q,
  input logic sel_rise,
  input logic sel_fall,
  input logic ck_fall,
  input logic lnk_rsp,
  input logic poll_err,
  input logic cmd_bad,
  input logic [15:0] btn_q,
  input logic [BW-1:0] byte_cnt
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sel_q |=> lnk_rsp);
  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!sel_q && !ck_fall) |=> $stable(lnk_rsp));
  // R6
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_cnt <= BW'(TOTAL));
  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_bad && !sel_q && ck_fall) |=> lnk_rsp);
  // R9
  btn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !sel_fall |=> $stable(btn_q));
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!sel_fall && !sel_rise) |=> $stable(poll_err));
endmodule

bind pad_link_responder pad_link_responder_chk #(.TOTAL(TOTAL), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sel_rise(sel_rise), .sel_fall(sel_fall),
  .ck_fall(ck_fall), .lnk_rsp(lnk_rsp), .poll_err(poll_err), .cmd_bad(cmd_bad),
  .btn_q(btn_q), .byte_cnt(byte_cnt)
);

// File: tb/sim_pad_link_responder.sv
module sim_pad_link_responder;
  localparam int HALF = 8;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b1, lk = 1'b1, sel_n = 1'b1, cmd = 1'b1;
  logic [15:0] btn = '1, ana = '1;
  logic r0, r1, e0, e1;
  int total_n = 0, bad_n = 0;
  logic [7:0] rx0 [9];
  logic [7:0] rx1 [9];
  bit unst;

  pad_link_responder #(.ANA_WORDS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .lnk_clk(lk), .lnk_sel_n(sel_n), .lnk_cmd(cmd),
    .lnk_rsp(r0), .btn_n(btn), .ana_in(ana), .poll_err(e0));
  pad_link_responder #(.ANA_WORDS(0)) u1 (
    .clk(clk), .rst_n(rst_n), .lnk_clk(lk), .lnk_sel_n(sel_n), .lnk_cmd(cmd),
    .lnk_rsp(r1), .btn_n(btn), .ana_in(ana), .poll_err(e1));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expb(int b, int tot, logic [7:0] id, logic [15:0] bt,
                                      logic [15:0] an, bit b0, bit b1);
    if (b >= tot || (b >= 1 && b0) || (b >= 2 && b1)) return 8'hFF;
    case (b)
      0: return 8'hFF;
      1: return id;
      2: return 8'h5A;
      3: return bt[7:0];
      4: return bt[15:8];
      5: return an[7:0];
      default: return an[15:8];
    endcase
  endfunction

  function automatic string reqof(int b, int tot, bit b0, bit b1);
    if (b0 && b >= 1) return "R7";
    if (b1 && b >= 2) return "R8";
    if (b >= tot) return "R6";
    if (b < 3) return "R3";
    if (b < 5) return "R4";
    return "R5";
  endfunction

  task automatic poll(input int nb, input logic [7:0] c0, input logic [7:0] c1,
                      input int chg_at, input logic [15:0] chg_val);
    logic [7:0] cb;
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    unst = 1'b0;
    for (int b = 0; b < nb; b++) begin
      if (b == chg_at) btn = chg_val;
      cb = (b == 0) ? c0 : (b == 1) ? c1 : 8'h00;
      for (int i = 0; i < 8; i++) begin
        lk = 1'b0;
        cmd = cb[i];
        repeat (HALF) @(negedge clk);
        rx0[b][i] = r0;
        rx1[b][i] = r1;
        lk = 1'b1;
        for (int k = 0; k < HALF; k++) begin
          @(negedge clk);
          if (r0 !== rx0[b][i] || r1 !== rx1[b][i]) unst = 1'b1;
        end
      end
    end
    sel_n = 1'b1;
    cmd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run(input int nb, input logic [7:0] c0, input logic [7:0] c1,
                     input int chg_at, input logic [15:0] chg_val, input logic [15:0] bt_exp);
    bit b0, b1;
    string tg;
    poll(nb, c0, c1, chg_at, chg_val);
    b0 = (nb >= 1) && (c0 != 8'h01);
    b1 = (nb >= 2) && !b0 && (c1 != 8'h42);
    for (int b = 0; b < nb; b++) begin
      chk(reqof(b, 7, b0, b1), 16'(rx0[b]), 16'(expb(b, 7, 8'h72, bt_exp, ana, b0, b1)));
      chk(reqof(b, 5, b0, b1), 16'(rx1[b]), 16'(expb(b, 5, 8'h41, bt_exp, ana, b0, b1)));
    end
    tg = b0 ? "R7" : b1 ? "R8" : "R10";
    chk(tg, 16'(e0), 16'(b0 || b1 || nb < 7));
    chk(tg, 16'(e1), 16'(b0 || b1 || nb < 5));
    chk("R1", {14'd0, r0, r1}, 16'd3);
    chk("R2", 16'(unst), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total_n++;
    bad_n++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", {12'd0, r0, r1, e0, e1}, 16'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {12'd0, r0, r1, e0, e1}, 16'b1100);

    for (int k = 0; k < 16; k++) begin
      btn = ~(16'h1 << k);
      ana = (16'h1111 * 16'(k)) ^ 16'h0F30;
      run(9, 8'h01, 8'h42, -1, 16'h0, btn);
    end
    btn = 16'h0000; ana = 16'hFFFF; run(9, 8'h01, 8'h42, -1, 16'h0, btn);
    btn = 16'hFFFF; ana = 16'h0000; run(9, 8'h01, 8'h42, -1, 16'h0, btn);
    btn = 16'hA55A; ana = 16'h3CC3; run(9, 8'h01, 8'h42, -1, 16'h0, btn);

    // R7: wrong first command byte
    run(9, 8'h03, 8'h42, -1, 16'h0, btn);
    // R8: wrong second command byte
    run(9, 8'h01, 8'h43, -1, 16'h0, btn);
    // R9: buttons change mid-poll
    btn = 16'h1234;
    run(9, 8'h01, 8'h42, 2, 16'hFFFF, 16'h1234);
    chk("R9", {rx0[4], rx0[3]}, 16'h1234);
    chk("R9", {rx1[4], rx1[3]}, 16'h1234);
    // R10: aborted poll then recovery
    btn = 16'h7E81;
    run(3, 8'h01, 8'h42, -1, 16'h0, btn);
    run(9, 8'h01, 8'h42, -1, 16'h0, btn);
    // R10 / R6: exact-length boundaries for each copy
    run(5, 8'h01, 8'h42, -1, 16'h0, btn);
    run(7, 8'h01, 8'h42, -1, 16'h0, btn);

    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule